// File: doc/BRIEF.md
# Leading and Trailing Zero Counter

This combinational unit sits in the logical stage of a 64-bit integer datapath. It takes an operand and returns how many consecutive zero bits there are. The count starts from either the most significant end (leading) or the least significant end (trailing). It can cover the whole 64-bit doubleword or only the low 32-bit word. The result comes back as a full-width value, with the count zero-extended.

A single priority encoder does the counting, and it always searches from the most significant end. The encoder is built in two levels: 4-bit groups first, then a choice of group. An input stage in front of the encoder handles direction and width. It bit-reverses the operand for trailing counts. In word mode it also moves the low word to the top and places a sentinel 1 just below it. The encoder itself never reverses or inverts anything.

Top module: `zero_count_unit`

## Requirements
- R1: With `trail_i`=0 and `word_i`=0, `count_o` equals the number of consecutive 0 bits starting at bit 63 and going down, stopping at the first 1.
- R2: With `trail_i`=1 and `word_i`=0, `count_o` equals the number of consecutive 0 bits starting at bit 0 and going up, stopping at the first 1.
- R3: With `word_i`=0, an all-zero operand gives `count_o`=64 in both directions.
- R4: Bits 63:7 of `count_o` are always 0 (the count is zero-extended).
- R5: With `trail_i`=0 and `word_i`=1, `count_o` counts zeros from bit 31 downward, stopping at the first 1 within bits 31:0.
- R6: With `trail_i`=1 and `word_i`=1, `count_o` counts zeros from bit 0 upward, stopping at the first 1 within bits 31:0.
- R7: With `word_i`=1, the result never exceeds 32, and bits 31:0 all zero give exactly 32 in both directions.
- R8: With `word_i`=1, operand bits 63:32 have no effect on `count_o`.
- R9: An all-ones operand gives 0 in all four modes.
- R10: Within each 4-bit group the encoder picks the highest-indexed set bit. This is seen at the ports because every single-set-bit operand yields the count of that bit's position in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | DATA_W (64) | Operand whose zero bits are counted |
| trail_i | input | 1 | 0 = count from the most significant end, 1 = from the least significant end |
| word_i | input | 1 | 0 = full 64-bit operand, 1 = low 32-bit word only |
| count_o | output | DATA_W (64) | Zero-extended zero count |

## Verification
The assertions assume only that the operand and both selects are known, settled values. With no clock or state inside the block, each assertion judges a single combinational evaluation. The stimulus drives every input to a defined value between clock edges and samples only at the opposite edge, after the inputs have settled. Random operands from a fixed seed are mixed with all-zero, all-one and every single-bit pattern across all four mode combinations. This covers group boundaries, the sentinel position and the word boundary.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;
   typedef enum logic {ZC_LEAD = 1'b0, ZC_TRAIL = 1'b1} zc_dir_e;
   typedef enum logic {ZC_DWORD = 1'b0, ZC_WORD = 1'b1} zc_width_e;

   function automatic bit zc_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/zcnt_operand_prep.sv
module zcnt_operand_prep
   import zcnt_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32
) (
   input  logic [DATA_W-1:0] operand_i,
   input  zc_dir_e           dir_i,
   input  zc_width_e         width_i,
   output logic [DATA_W-1:0] enc_in_o
);
   localparam int PAD_W = DATA_W - WORD_W;
   localparam logic [PAD_W-1:0] SENTINEL = PAD_W'(1) << (PAD_W - 1);

   logic [DATA_W-1:0] rev_full;
   logic [WORD_W-1:0] rev_word;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
      assign rev_full[i] = operand_i[DATA_W-1-i];
   end
   for (genvar j = 0; j < WORD_W; j++) begin : g_rev_word
      assign rev_word[j] = operand_i[WORD_W-1-j];
   end

   always_comb begin
      unique case ({width_i, dir_i})
         {ZC_DWORD, ZC_LEAD}:  enc_in_o = operand_i;
         {ZC_DWORD, ZC_TRAIL}: enc_in_o = rev_full;
         {ZC_WORD,  ZC_LEAD}:  enc_in_o = {operand_i[WORD_W-1:0], SENTINEL};
         default:              enc_in_o = {rev_word, SENTINEL};
      endcase
   end

   always_comb begin
      if (width_i == ZC_WORD)
         p_sentinel_set_r7: assert (enc_in_o[PAD_W-1] == 1'b1)
            else $error("word mode lost its sentinel bit");
   end
endmodule

// File: rtl/zcnt_group_enc.sv
module zcnt_group_enc #(
   parameter int GRP_W = 4,
   localparam int IDX_W = $clog2(GRP_W)
) (
   input  logic [GRP_W-1:0] bits_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int b = 0; b < GRP_W; b++) begin
         if (bits_i[b]) idx_o = IDX_W'(b);
      end
   end
   assign any_o = |bits_i;

   always_comb begin
      if (any_o)
         p_grp_highest_r10: assert ((bits_i >> idx_o) == GRP_W'(1))
            else $error("group encoder did not pick the top set bit");
   end
endmodule

// File: rtl/zcnt_prio_enc.sv
module zcnt_prio_enc #(
   parameter int DATA_W = 64,
   parameter int GRP_W  = 4,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam int NGRP   = DATA_W / GRP_W;
   localparam int IDX_W  = $clog2(GRP_W);
   localparam int GSEL_W = $clog2(NGRP);
   localparam int POS_W  = GSEL_W + IDX_W;

   logic [NGRP-1:0]  grp_any;
   logic [IDX_W-1:0] grp_idx [NGRP];
   logic [GSEL_W-1:0] sel;
   logic [POS_W-1:0]  pos;
   logic              found;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      zcnt_group_enc #(.GRP_W(GRP_W)) i_grp (
         .bits_i (data_i[g*GRP_W +: GRP_W]),
         .any_o  (grp_any[g]),
         .idx_o  (grp_idx[g])
      );
   end

   always_comb begin
      sel = '0;
      for (int g = 0; g < NGRP; g++) begin
         if (grp_any[g]) sel = GSEL_W'(g);
      end
   end

   assign found = |grp_any;
   assign pos   = {sel, grp_idx[sel]};
   assign cnt_o = found ? (CNT_W'(DATA_W - 1) - CNT_W'(pos)) : CNT_W'(DATA_W);

   always_comb begin
      if (found) begin
         p_enc_first_one_r1: assert (((data_i << cnt_o) >> (DATA_W - 1)) == DATA_W'(1))
            else $error("encoder count does not land on the first one");
      end else begin
         p_enc_empty_r3: assert (data_i == '0 && cnt_o == CNT_W'(DATA_W))
            else $error("encoder empty case mismatch");
      end
   end
endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit
   import zcnt_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int WORD_W = 32,
   parameter int GRP_W  = 4
) (
   input  logic [DATA_W-1:0] operand_i,
   input  logic              trail_i,
   input  logic              word_i,
   output logic [DATA_W-1:0] count_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   if (!zc_is_pow2(GRP_W) || GRP_W < 2) begin : g_bad_grp
      $error("GRP_W must be a power of two of at least 2");
   end
   if (DATA_W % GRP_W != 0 || DATA_W / GRP_W < 2 || !zc_is_pow2(DATA_W / GRP_W)) begin : g_bad_data
      $error("DATA_W must be a power-of-two count (>=2) of groups");
   end
   if (WORD_W < 1 || DATA_W - WORD_W < 1) begin : g_bad_word
      $error("WORD_W must be narrower than DATA_W");
   end

   zc_dir_e           dir;
   zc_width_e         width;
   logic [DATA_W-1:0] enc_in;
   logic [CNT_W-1:0]  cnt;

   assign dir   = zc_dir_e'(trail_i);
   assign width = zc_width_e'(word_i);

   zcnt_operand_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_prep (
      .operand_i (operand_i),
      .dir_i     (dir),
      .width_i   (width),
      .enc_in_o  (enc_in)
   );

   zcnt_prio_enc #(.DATA_W(DATA_W), .GRP_W(GRP_W)) i_enc (
      .data_i (enc_in),
      .cnt_o  (cnt)
   );

   assign count_o = {{(DATA_W - CNT_W){1'b0}}, cnt};

   always_comb begin
      if (!word_i && operand_i == '0)
         p_full_zero_r3: assert (count_o == DATA_W'(DATA_W))
            else $error("all-zero doubleword not counted as full width");
      if (word_i)
         p_word_bound_r7: assert (count_o <= DATA_W'(WORD_W))
            else $error("word-mode count beyond word width");
      if (trail_i && !word_i && operand_i != '0)
         p_trail_first_one_r2: assert (((operand_i >> cnt) & DATA_W'(1)) == DATA_W'(1))
            else $error("trailing count does not reach the first one");
      if (!trail_i && word_i && operand_i[WORD_W-1:0] != '0)
         p_word_lead_r5: assert (((operand_i >> (CNT_W'(WORD_W - 1) - cnt)) & DATA_W'(1)) == DATA_W'(1))
            else $error("word leading count does not reach the first one");
   end
endmodule

// File: tb/test_zero_count_unit.sv
module test_zero_count_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] operand;
   logic        trail;
   logic        word;
   logic [63:0] count;
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          done     = 1'b0;

   always #4 clk = ~clk;

   zero_count_unit i_zero_count_unit (
      .operand_i (operand),
      .trail_i   (trail),
      .word_i    (word),
      .count_o   (count)
   );

   function automatic logic [63:0] model(input logic [63:0] op, input logic tr, input logic wd);
      int width = wd ? 32 : 64;
      int n = 0;
      for (int k = 0; k < width; k++) begin
         if (op[tr ? k : width - 1 - k]) break;
         n++;
      end
      return 64'(n);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s op=%h trail=%0b word=%0b actual=%0d expected=%0d",
                  req, operand, trail, word, act, exp);
      end
   endtask

   function automatic string tag_for(input logic tr, input logic wd);
      if (!wd) return tr ? "R2" : "R1";
      return tr ? "R6" : "R5";
   endfunction

   task automatic apply(input logic [63:0] op, input logic tr, input logic wd, input string req);
      @(posedge clk);
      operand = op; trail = tr; word = wd;
      @(negedge clk);
      check(req, count, model(op, tr, wd));
      check("R4", {count[63:7], 7'b0}, 64'd0);
   endtask

   initial begin
      operand = '0; trail = 1'b0; word = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R3", count, 64'd64);
      process::self().srandom(32'h5eed_0c17);
      for (int m = 0; m < 4; m++) begin
         logic tr = m[0];
         logic wd = m[1];
         apply(64'd0, tr, wd, wd ? "R7" : "R3");
         apply('1, tr, wd, "R9");
         for (int b = 0; b < 64; b++) apply(64'd1 << b, tr, wd, "R10");
         apply(64'hFFFF_FFFF_0000_0000, tr, wd, wd ? "R7" : tag_for(tr, wd));
         for (int r = 0; r < 300; r++) begin
            logic [63:0] v = {$urandom, $urandom};
            v = v >> ($urandom % 64);
            if (r[0]) v = v << ($urandom % 64);
            apply(v, tr, wd, tag_for(tr, wd));
         end
      end
      for (int r = 0; r < 100; r++) begin
         logic [31:0] lo = $urandom >> ($urandom % 32);
         logic [63:0] ref_cnt;
         for (int tr = 0; tr < 2; tr++) begin
            apply({32'd0, lo}, tr[0], 1'b1, "R8");
            ref_cnt = count;
            apply({$urandom, lo}, tr[0], 1'b1, "R8");
            check("R8", count, ref_cnt);
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule